// File: doc/BRIEF.md
# Solenoid Strike Controller

This block drives a single key solenoid through three states: off, attack and hold. A start strobe fires a full-power attack pulse. Its length, counted in system clock cycles, sets how hard the key is struck. When the pulse ends, the block waits through an optional gap with the drive off. It then modulates the hold output with a PWM waveform, which keeps the key down for the sustain part of the note. The hold continues until a release strobe arrives.

The PWM counter runs from a power-of-two prescaler chosen by a 4-bit code. The hold duty is taken only at period boundaries, so a change written in the middle of a period cannot cut a pulse short. The attack length and the gap are captured when start is sampled. A register bus can therefore rewrite them while a note is sounding without disturbing that note.

Top module: `sol_strike_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `attack_o` and `hold_pwm_o` are 0 and `state_o` reads 0. Both outputs stay low until a start is sampled.
- R2: A start sampled at an edge raises `attack_o` from that edge onward for exactly N cycles. N is the `atk_len_i` value sampled with the start, and a value of 0 behaves as 1. The 20-bit field reaches 1048575 cycles, which covers 250 us to 30 ms at 16 MHz.
- R3: After the attack, both outputs stay low for D cycles, where D is the `hold_dly_i` value sampled with the start. The hold PWM begins in the cycle after that. With D = 0, the hold begins directly after the attack.
- R4: `state_o` encodes 0 for off, 1 for attack and 2 for hold. The gap after the attack reads 2.
- R5: In hold cycle h (h = 0 in the first hold cycle), the PWM count equals floor(h / div) mod 256. `hold_pwm_o` is 1 exactly when that count is below the latched duty.
- R6: Prescaler code v in 1..15 gives div = 2^(v-1), so code 1 divides by 1 and code 15 divides by 16384. Code 0 behaves as code 1.
- R7: The duty is latched from `duty_i` at the edge that starts each PWM period, including the first hold cycle. A change to `duty_i` in the middle of a period has no effect until the next period.
- R8: A sampled release returns the block to off at that edge, with both outputs low, whatever the current state. Release takes priority over a start in the same cycle.
- R9: A start sampled during attack, gap or hold restarts the attack from its first cycle, using newly sampled length and gap values.
- R10: `attack_o` and `hold_pwm_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, one cycle per note |
| release_i | input | 1 | Release strobe |
| atk_len_i | input | 20 | Attack length in clock cycles |
| hold_dly_i | input | 20 | Gap between attack and hold, in clock cycles |
| duty_i | input | 8 | Hold PWM duty, out of 256 |
| presc_code_i | input | 4 | Prescaler code for the PWM counter |
| attack_o | output | 1 | Full-power drive enable |
| hold_pwm_o | output | 1 | Hold PWM drive |
| state_o | output | 2 | Solenoid state: 0 off, 1 attack, 2 hold |

## Verification
The assertions treat start and release as values sampled at each edge. They assume that start sets up a fresh count and that release always wins. They do not assume that the prescaler code stays constant during a hold. The sequencer properties therefore assume only that the length and gap are taken at start.

The stimulus changes the prescaler code and the lengths only in the cycle that carries a start. It changes the duty in the middle of a hold in one scenario, and never in cycle zero of a hold. This keeps every predicted waveform tied to the values that applied when the note began.

// File: rtl/sol_pkg.sv
package sol_pkg;

    localparam int CODE_W = 4;
    localparam int SHIFT_MAX = (1 << CODE_W) - 2;

    typedef enum logic [1:0] {
        PH_OFF    = 2'd0,
        PH_ATTACK = 2'd1,
        PH_GAP    = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        SOL_OFF    = 2'd0,
        SOL_ATTACK = 2'd1,
        SOL_HOLD   = 2'd2
    } sol_state_e;

    typedef struct packed {
        logic       attack;
        logic       hold_run;
        sol_state_e state;
    } drive_s;

    // code 0 is folded onto code 1; code v selects a shift of v-1
    function automatic logic [CODE_W-1:0] code_shift(input logic [CODE_W-1:0] code);
        return (code == '0) ? '0 : code - CODE_W'(1);
    endfunction

    function automatic drive_s decode_phase(input phase_e ph);
        drive_s d;
        d.attack   = (ph == PH_ATTACK);
        d.hold_run = (ph == PH_HOLD);
        unique case (ph)
            PH_OFF:    d.state = SOL_OFF;
            PH_ATTACK: d.state = SOL_ATTACK;
            default:   d.state = SOL_HOLD;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sol_seq.sv
module sol_seq
    import sol_pkg::*;
#(
    parameter int ATK_W = 20,
    parameter int DLY_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             release_i,
    input  logic [ATK_W-1:0] atk_len_i,
    input  logic [DLY_W-1:0] hold_dly_i,
    output phase_e           phase_o
);

    localparam int CW = (ATK_W > DLY_W) ? ATK_W : DLY_W;

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] atk_q;
    logic [CW-1:0] dly_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_OFF;
            cnt_q   <= '0;
            atk_q   <= CW'(1);
            dly_q   <= '0;
        end else if (release_i) begin
            phase_q <= PH_OFF;
            cnt_q   <= '0;
        end else if (start_i) begin
            phase_q <= PH_ATTACK;
            cnt_q   <= '0;
            atk_q   <= (atk_len_i == '0) ? CW'(1) : CW'(atk_len_i);
            dly_q   <= CW'(hold_dly_i);
        end else begin
            unique case (phase_q)
                PH_ATTACK: begin
                    if (cnt_q == atk_q - CW'(1)) begin
                        cnt_q   <= '0;
                        phase_q <= (dly_q == '0) ? PH_HOLD : PH_GAP;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                PH_GAP: begin
                    if (cnt_q == dly_q - CW'(1)) begin
                        cnt_q   <= '0;
                        phase_q <= PH_HOLD;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                default: begin
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign phase_o = phase_q;

    // R9: a start without release always opens a fresh attack
    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (start_i && !release_i) |=> (phase_q == PH_ATTACK && cnt_q == '0));

    // R2: the attack count never passes the latched length
    p_attack_len_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ATTACK) |-> (cnt_q < atk_q));

    // R3: hold persists until a strobe arrives
    p_hold_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HOLD && !start_i && !release_i) |=> (phase_q == PH_HOLD));

endmodule

// File: rtl/sol_prescale.sv
module sol_prescale
    import sol_pkg::*;
#(
    parameter int SHIFT_W = SHIFT_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o
);

    localparam int CNT_W = (SHIFT_W < 1) ? 1 : SHIFT_W;

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  limit;
    logic [CNT_W-1:0]  ones;
    logic [CODE_W-1:0] sh;

    always_comb begin
        ones  = '1;
        sh    = code_shift(code_i);
        limit = ~(ones << sh);
    end

    // >= keeps the counter from running away when the code shrinks mid-hold
    assign tick_o = run_i && (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R6: the divider restarts from zero whenever the hold stops
    p_presc_restart_r6: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (cnt_q == '0));

    // R6: after a tick the divider begins a new interval
    p_presc_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (tick_o && run_i) |=> (cnt_q == '0));

endmodule

// File: rtl/sol_pwm.sv
module sol_pwm #(
    parameter int PWM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [PWM_W-1:0] duty_i,
    output logic             pwm_o
);

    logic [PWM_W-1:0] pcnt_q;
    logic [PWM_W-1:0] duty_q;
    logic             wrap;

    assign wrap = tick_i && (pcnt_q == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
            duty_q <= '0;
        end else if (!run_i) begin
            pcnt_q <= '0;
            duty_q <= duty_i;
        end else if (tick_i) begin
            pcnt_q <= pcnt_q + PWM_W'(1);
            if (wrap) begin
                duty_q <= duty_i;
            end
        end
    end

    assign pwm_o = run_i && (pcnt_q < duty_q);

    // R5: every hold begins at count zero
    p_pwm_first_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(run_i) |-> (pcnt_q == '0));

    // R7: duty is frozen inside a running period
    p_duty_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (run_i && !wrap) |=> (!run_i || $stable(duty_q)));

endmodule

// File: rtl/sol_strike_ctrl.sv
module sol_strike_ctrl
    import sol_pkg::*;
#(
    parameter int ATK_W = 20,
    parameter int DLY_W = 20,
    parameter int PWM_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              release_i,
    input  logic [ATK_W-1:0]  atk_len_i,
    input  logic [DLY_W-1:0]  hold_dly_i,
    input  logic [PWM_W-1:0]  duty_i,
    input  logic [CODE_W-1:0] presc_code_i,
    output logic              attack_o,
    output logic              hold_pwm_o,
    output logic [1:0]        state_o
);

    phase_e phase;
    drive_s drv;
    logic   tick;

    sol_seq #(
        .ATK_W(ATK_W),
        .DLY_W(DLY_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .release_i (release_i),
        .atk_len_i (atk_len_i),
        .hold_dly_i(hold_dly_i),
        .phase_o   (phase)
    );

    assign drv = decode_phase(phase);

    sol_prescale #(
        .SHIFT_W(SHIFT_MAX)
    ) u_presc (
        .clk   (clk),
        .rst   (rst),
        .run_i (drv.hold_run),
        .code_i(presc_code_i),
        .tick_o(tick)
    );

    sol_pwm #(
        .PWM_W(PWM_W)
    ) u_pwm (
        .clk   (clk),
        .rst   (rst),
        .run_i (drv.hold_run),
        .tick_i(tick),
        .duty_i(duty_i),
        .pwm_o (hold_pwm_o)
    );

    assign attack_o = drv.attack;
    assign state_o  = drv.state;

    // R10: full power and hold drive are mutually exclusive
    p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !(attack_o && hold_pwm_o));

    // R8: release silences everything on the next edge
    p_release_off_r8: assert property (@(posedge clk) disable iff (rst)
        release_i |=> (state_o == 2'd0 && !attack_o && !hold_pwm_o));

    // R4: state code tracks the attack output
    p_state_attack_r4: assert property (@(posedge clk) disable iff (rst)
        attack_o |-> (state_o == 2'd1));

endmodule

// File: tb/sim_sol_strike_ctrl.sv
module sim_sol_strike_ctrl;

    typedef struct {
        logic       a;
        logic       p;
        logic [1:0] s;
        int         req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        release_i = 1'b0;
    logic [19:0] atk_len_i = '0;
    logic [19:0] hold_dly_i = '0;
    logic [7:0]  duty_i = '0;
    logic [3:0]  presc_code_i = 4'd1;
    logic        attack_o;
    logic        hold_pwm_o;
    logic [1:0]  state_o;

    int   checks = 0;
    int   errors = 0;
    exp_t q[$];

    always #4 clk = ~clk;

    sol_strike_ctrl u0 (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .release_i   (release_i),
        .atk_len_i   (atk_len_i),
        .hold_dly_i  (hold_dly_i),
        .duty_i      (duty_i),
        .presc_code_i(presc_code_i),
        .attack_o    (attack_o),
        .hold_pwm_o  (hold_pwm_o),
        .state_o     (state_o)
    );

    // monitor: pops one expected item per edge and compares
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (attack_o !== e.a || hold_pwm_o !== e.p || state_o !== e.s) begin
                    errors++;
                    $display("FAIL R%0d t=%0t actual a=%b p=%b s=%0d expected a=%b p=%b s=%0d",
                             e.req, $time, attack_o, hold_pwm_o, state_o, e.a, e.p, e.s);
                end
                checks++;
                if (attack_o === 1'b1 && hold_pwm_o === 1'b1) begin
                    errors++;
                    $display("FAIL R10 t=%0t actual a=1 p=1 expected not both", $time);
                end
            end
        end
    end

    task automatic push(logic a, logic p, logic [1:0] s, int rq);
        exp_t e;
        e.a = a; e.p = p; e.s = s; e.req = rq;
        q.push_back(e);
    endtask

    // one idle or strobe cycle whose expected result is off
    task automatic drive_off(bit st, bit rl, int rq);
        @(negedge clk);
        start_i   = st;
        release_i = rl;
        push(1'b0, 1'b0, 2'd0, rq);
    endtask

    // R8: release strobe
    task automatic release_note();
        drive_off(1'b0, 1'b1, 8);
        @(negedge clk);
        release_i = 1'b0;
        push(1'b0, 1'b0, 2'd0, 8);
    endtask

    // runs n cycles of a note that starts in its first cycle
    task automatic note(int atk, int dly, int d0, int code, int n, int d1, int chg, int rq);
        int alen;
        int dv;
        alen = (atk == 0) ? 1 : atk;
        dv   = 1 << ((code == 0) ? 0 : code - 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            release_i = 1'b0;
            if (i == 0) begin
                atk_len_i    = 20'(atk);
                hold_dly_i   = 20'(dly);
                duty_i       = 8'(d0);
                presc_code_i = 4'(code);
                start_i      = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            if (i < alen) begin
                push(1'b1, 1'b0, 2'd1, rq);
            end else if (i < alen + dly) begin
                push(1'b0, 1'b0, 2'd2, rq);
            end else begin
                int h;
                int per;
                int deff;
                h = i - alen - dly;
                if (chg >= 0 && h == chg) duty_i = 8'(d1);
                per  = (h / dv) / 256;
                deff = (chg >= 0 && per >= 1 && per * 256 * dv >= chg) ? d1 : d0;
                push(1'b0, ((h / dv) % 256) < deff, 2'd2, rq);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R0 watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            push(1'b0, 1'b0, 2'd0, 1);
        end
        @(negedge clk);
        rst = 1'b0;
        push(1'b0, 1'b0, 2'd0, 1);
        drive_off(1'b0, 1'b0, 1);

        // R2 R3 R4 R5: basic note with gap
        note(5, 3, 100, 1, 5 + 3 + 300, 0, -1, 5);
        release_note();
        // R3: zero gap goes straight to hold
        note(1, 0, 64, 1, 1 + 40, 0, -1, 3);
        release_note();
        // R2: length 0 acts as 1
        note(0, 2, 10, 1, 1 + 2 + 20, 0, -1, 2);
        release_note();
        // R2: 250 us at 16 MHz
        note(4000, 0, 128, 1, 4000 + 10, 0, -1, 2);
        release_note();
        // R6: code 3 divides by 4
        note(3, 1, 3, 3, 3 + 1 + 1100, 0, -1, 6);
        release_note();
        // R6: code 0 acts as code 1
        note(2, 0, 5, 0, 2 + 20, 0, -1, 6);
        release_note();
        // R6: code 15 divides by 16384
        note(2, 0, 2, 15, 2 + 32768 + 20, 0, -1, 6);
        release_note();
        // R7: mid-period duty change waits for the next period
        note(2, 1, 100, 1, 3 + 600, 200, 50, 7);
        release_note();
        // R9: restart during attack, gap and hold
        note(20, 5, 50, 1, 6, 0, -1, 9);
        note(4, 8, 50, 1, 4 + 3, 0, -1, 9);
        note(3, 0, 50, 1, 3 + 20, 0, -1, 9);
        note(2, 0, 80, 1, 2 + 30, 0, -1, 9);
        release_note();
        // R8: release during attack and during gap
        note(10, 2, 50, 1, 4, 0, -1, 8);
        release_note();
        note(2, 6, 50, 1, 4, 0, -1, 8);
        release_note();
        // R8: release wins over a simultaneous start
        drive_off(1'b1, 1'b1, 8);
        drive_off(1'b0, 1'b0, 8);
        drive_off(1'b0, 1'b0, 8);

        @(posedge clk);
        #3;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule